// File: doc/BRIEF.md
# External Interrupt Edge Timer

This block watches a set of asynchronous external interrupt pins. Each pin passes through a two-flop synchronizer and then an edge detector. Each channel has its own configuration word: an enable bit and a two-bit edge selector, which chooses the falling edge, the rising edge or both edges. When an enabled channel sees an edge of the selected kind, it drives its interrupt output high for exactly one clock.

The lower-numbered channels each also have a 16-bit interval timer. The timer counts system clocks and returns to zero on every qualifying edge, so software can read how much time has passed since the last interrupt on that channel. The timer stops and holds its value while its channel is disabled. A small word-addressed 16-bit register port gives read/write access to the configuration words and read-only access to the timers.

Top module: `xirq_edge_timer`

## Requirements
- R1: After reset every configuration word, every timer and every interrupt output is zero.
- R2: The configuration word of channel k (k = 0..4) is at word address k. Bit 0 is the enable bit and bits 3:2 are the edge selector. Every other bit reads as 0 and ignores writes.
- R3: Edge selector codes: 00 and 10 select the falling edge, 01 selects the rising edge, 11 selects both edges.
- R4: A qualifying edge on an enabled channel raises that channel's interrupt for exactly one clock. The pulse appears three clocks after the pin changes, counting the two synchronizer flops and the output flop. An edge of the other kind produces no pulse.
- R5: A disabled channel produces no interrupt pulse.
- R6: The timer of channel k (k = 0..2) is at word address 8+k. While its channel is enabled it rises by one on every clock and wraps from 0xFFFF to 0x0000.
- R7: A qualifying edge clears the timer to 0. If a clear and an increment fall in the same cycle, the clear wins. An edge of the other kind does not clear the timer.
- R8: While the channel is disabled, its timer holds its value, and edges do not clear it.
- R9: Bus writes to the timer addresses have no effect.
- R10: Reads from reserved addresses return 0. Writes to reserved addresses change no register.
- R11: Read data is registered and appears on the clock after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| pin_i | input | 5 | Asynchronous external interrupt pins, one per channel |
| bus_addr_i | input | 4 | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 5 | One-clock interrupt pulses, one per channel |

## Verification
A wrong edge-selector decode or a wrong enable gate shows up directly on irq_o, three clocks after the pin changes: either a pulse that should not appear or a pulse that is missing. A timer that clears on the wrong edge, keeps counting while disabled or takes a bus write shows up at the next timer read, as a value that is off by a known number of clocks. A configuration bit that is not masked or decoded correctly shows up on the first read-back after the write.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   typedef enum logic [1:0] {
      SEL_FALL0 = 2'b00,
      SEL_RISE  = 2'b01,
      SEL_FALL1 = 2'b10,
      SEL_BOTH  = 2'b11
   } edge_sel_e;

   typedef struct packed {
      edge_sel_e sel;
      logic      en;
   } chan_cfg_t;

   localparam int unsigned CFG_EN_BIT  = 0;
   localparam int unsigned CFG_SEL_LSB = 2;

   function automatic logic edge_qualifies(edge_sel_e sel, logic rise, logic fall);
      case (sel)
         SEL_RISE: return rise;
         SEL_BOTH: return rise | fall;
         default:  return fall;
      endcase
   endfunction
endpackage

// File: rtl/xirq_sync_edge.sv
module xirq_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   initial begin
      if (STAGES < 2) $error("xirq_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;
   assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/xirq_channel.sv
module xirq_channel
   import xirq_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter bit          HAS_CNT = 1'b1,
   parameter int unsigned STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  chan_cfg_t        cfg_i,
   output logic             irq_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic rise, fall, hit;

   xirq_sync_edge #(.STAGES(STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_i),
      .rise_o(rise),
      .fall_o(fall)
   );

   assign hit = cfg_i.en & edge_qualifies(cfg_i.sel, rise, fall);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= hit;
   end

   generate
      if (HAS_CNT) begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        cnt_q <= '0;
            else if (hit)      cnt_q <= '0;
            else if (cfg_i.en) cnt_q <= cnt_q + 1'b1;
         end
         assign cnt_o = cnt_q;
      end else begin : g_nocnt
         assign cnt_o = '0;
      end
   endgenerate
endmodule

// File: rtl/xirq_regfile.sv
module xirq_regfile
   import xirq_pkg::*;
#(
   parameter int unsigned N_CH   = 5,
   parameter int unsigned N_CNT  = 3,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CNT_BASE = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic                         wr_i,
   input  logic                         rd_i,
   input  logic [DATA_W-1:0]            wdata_i,
   input  logic [N_CNT-1:0][CNT_W-1:0]  cnt_i,
   output chan_cfg_t [N_CH-1:0]         cfg_o,
   output logic [DATA_W-1:0]            rdata_o
);
   initial begin
      if (N_CNT > N_CH) $error("xirq_regfile: N_CNT exceeds N_CH");
      if (N_CH > CNT_BASE) $error("xirq_regfile: config window overlaps timers");
      if (CNT_BASE + N_CNT > (1 << ADDR_W)) $error("xirq_regfile: address too narrow");
      if (CNT_W > DATA_W) $error("xirq_regfile: CNT_W exceeds DATA_W");
   end

   chan_cfg_t [N_CH-1:0] cfg_q;

   for (genvar k = 0; k < N_CH; k++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_q[k] <= '{sel: SEL_FALL0, en: 1'b0};
         end else if (wr_i && addr_i == ADDR_W'(k)) begin
            cfg_q[k].en  <= wdata_i[CFG_EN_BIT];
            cfg_q[k].sel <= edge_sel_e'(wdata_i[CFG_SEL_LSB +: 2]);
         end
      end
   end
   assign cfg_o = cfg_q;

   logic [DATA_W-1:0] rmux;
   always_comb begin
      rmux = '0;
      for (int k = 0; k < N_CH; k++) begin
         if (addr_i == ADDR_W'(k)) begin
            rmux[CFG_EN_BIT]          = cfg_q[k].en;
            rmux[CFG_SEL_LSB +: 2]    = cfg_q[k].sel;
         end
      end
      for (int k = 0; k < N_CNT; k++) begin
         if (addr_i == ADDR_W'(CNT_BASE + k)) rmux = DATA_W'(cnt_i[k]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= rmux;
   end
endmodule

// File: rtl/xirq_edge_timer.sv
module xirq_edge_timer
   import xirq_pkg::*;
#(
   parameter int unsigned N_CH     = 5,
   parameter int unsigned N_CNT    = 3,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned CNT_BASE = 8,
   parameter int unsigned STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   pin_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic [N_CH-1:0]   irq_o
);
   chan_cfg_t [N_CH-1:0]         cfg;
   logic [N_CH-1:0][CNT_W-1:0]   cnt_all;
   logic [N_CNT-1:0][CNT_W-1:0]  cnt;

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      xirq_channel #(
         .CNT_W  (CNT_W),
         .HAS_CNT(k < N_CNT),
         .STAGES (STAGES)
      ) u_ch (
         .clk  (clk),
         .rst_n(rst_n),
         .pin_i(pin_i[k]),
         .cfg_i(cfg[k]),
         .irq_o(irq_o[k]),
         .cnt_o(cnt_all[k])
      );
   end

   for (genvar k = 0; k < N_CNT; k++) begin : g_cm
      assign cnt[k] = cnt_all[k];
   end

   xirq_regfile #(
      .N_CH(N_CH), .N_CNT(N_CNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .CNT_W(CNT_W), .CNT_BASE(CNT_BASE)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (bus_addr_i),
      .wr_i   (bus_wr_i),
      .rd_i   (bus_rd_i),
      .wdata_i(bus_wdata_i),
      .cnt_i  (cnt),
      .cfg_o  (cfg),
      .rdata_o(bus_rdata_o)
   );
endmodule

// File: rtl/xirq_edge_timer_chk.sv
module xirq_edge_timer_chk
   import xirq_pkg::*;
#(
   parameter int unsigned N_CH  = 5,
   parameter int unsigned N_CNT = 3,
   parameter int unsigned CNT_W = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [N_CH-1:0]            irq_o,
   input chan_cfg_t [N_CH-1:0]       cfg,
   input logic [N_CNT-1:0][CNT_W-1:0] cnt
);
   for (genvar k = 0; k < N_CH; k++) begin : g_a
      // R4: a pulse lasts one clock
      a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[k] |=> !irq_o[k]);
      // R5: a pulse needs the channel enabled in the cycle before it
      a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[k] |-> $past(cfg[k].en));
   end
   for (genvar k = 0; k < N_CNT; k++) begin : g_c
      // R8: a disabled channel's timer holds its value
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg[k].en |=> $stable(cnt[k]));
      // R6/R7: an enabled timer increments or clears
      a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg[k].en && !$isunknown(cnt[k])) |=>
            (cnt[k] == CNT_W'($past(cnt[k]) + 1'b1) || cnt[k] == '0));
      // R7: the timer reads zero in the same cycle the pulse appears
      a_r7_clear_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[k] |-> cnt[k] == '0);
   end
endmodule

bind xirq_edge_timer xirq_edge_timer_chk #(.N_CH(N_CH), .N_CNT(N_CNT), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .cfg(cfg), .cnt(cnt)
);

// File: tb/xirq_edge_timer_tb.sv
module xirq_edge_timer_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [4:0]  pin = '0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [4:0]  irq;
   int n_cmp = 0, n_bad = 0;
   logic [4:0]  irq_seen;

   always #(CLK_PERIOD/2) clk = ~clk;

   xirq_edge_timer u_dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   always @(negedge clk) irq_seen <= irq_seen | irq;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
      addr = a; wdata = d; wr = 1'b1;
      tick();
      wr = 1'b0;
   endtask

   // the read strobe is sampled at an edge; the data is valid after that edge
   task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
      addr = a; rd = 1'b1;
      tick();
      rd = 1'b0;
      d = rdata;
   endtask

   // one vector: channel, selector code, pin level before, pin level after, pulse expected
   typedef struct packed {
      logic [2:0] ch;
      logic [1:0] sel;
      logic       from;
      logic       to;
      logic       pulse;
   } vec_t;
   localparam vec_t VECS [12] = '{
      '{3'd0, 2'b00, 1'b1, 1'b0, 1'b1}, '{3'd0, 2'b00, 1'b0, 1'b1, 1'b0},
      '{3'd1, 2'b01, 1'b0, 1'b1, 1'b1}, '{3'd1, 2'b01, 1'b1, 1'b0, 1'b0},
      '{3'd2, 2'b10, 1'b1, 1'b0, 1'b1}, '{3'd2, 2'b10, 1'b0, 1'b1, 1'b0},
      '{3'd3, 2'b11, 1'b0, 1'b1, 1'b1}, '{3'd3, 2'b11, 1'b1, 1'b0, 1'b1},
      '{3'd4, 2'b01, 1'b0, 1'b1, 1'b1}, '{3'd4, 2'b00, 1'b0, 1'b1, 1'b0},
      '{3'd0, 2'b11, 1'b1, 1'b0, 1'b1}, '{3'd1, 2'b10, 1'b0, 1'b1, 1'b0}
   };

   initial begin
      logic [15:0] v, v2;
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1: everything is zero after reset
      for (int a = 0; a < 16; a++) begin
         rd_reg(a[3:0], v);
         check("R1 reset read", v, 16'h0);
      end
      check("R1 irq after reset", {11'h0, irq}, 16'h0);

      // R2: unused bits are masked on read-back
      wr_reg(4'd2, 16'hFFFF);
      rd_reg(4'd2, v);
      check("R2 mask", v, 16'h000D);
      wr_reg(4'd2, 16'h0000);

      // R3/R4: walk the vector table
      foreach (VECS[i]) begin
         vec_t t = VECS[i];
         pin[t.ch] = t.from;
         tick(4);
         wr_reg({1'b0, t.ch}, {12'h0, t.sel, 2'b01});
         tick(2);
         irq_seen = '0;
         pin[t.ch] = t.to;
         // the pin changed at t0; the pulse lands three edges later
         tick(2);
         check("R4 no early pulse", {15'h0, irq[t.ch]}, 16'h0);
         tick();
         check("R4 pulse timing", {15'h0, irq[t.ch]}, {15'h0, t.pulse});
         tick();
         check("R4 one-cycle width", {15'h0, irq[t.ch]}, 16'h0);
         check("R3 pulse per selector", {15'h0, irq_seen[t.ch]}, {15'h0, t.pulse});
         wr_reg({1'b0, t.ch}, 16'h0);
      end
      pin = '0;
      tick(4);

      // R5 and R8: a disabled channel gives no pulse and its timer does not clear
      wr_reg(4'd0, 16'h0005);
      tick(20);
      wr_reg(4'd0, 16'h0004);
      rd_reg(4'd8, v);
      irq_seen = '0;
      pin[0] = 1'b1;
      tick(6);
      check("R5 disabled no pulse", {15'h0, irq_seen[0]}, 16'h0);
      rd_reg(4'd8, v2);
      check("R8 hold while disabled", v2, v);

      // R6: count rate; enable, then read after a known gap
      wr_reg(4'd1, 16'h0001);
      rd_reg(4'd9, v);
      tick(9);
      rd_reg(4'd9, v2);
      check("R6 increment rate", v2 - v, 16'd10);

      // R9: a write to a timer address has no effect
      wr_reg(4'd9, 16'h1234);
      rd_reg(4'd9, v);
      check("R9 write ignored", v, v2 + 16'd2);

      // R7: a rising edge with the selector on falling does not clear; a falling edge clears
      wr_reg(4'd2, 16'h0001);
      tick(30);
      pin[2] = 1'b1;
      tick(6);
      rd_reg(4'd10, v);
      check("R7 wrong edge no clear", {15'h0, v > 16'd30}, 16'h1);
      pin[2] = 1'b0;
      tick(3);
      // the clear edge is at t+3; the read is registered one edge later
      rd_reg(4'd10, v);
      check("R7 clear then count", v, 16'd0);
      rd_reg(4'd10, v);
      check("R7 counts from zero", v, 16'd1);

      // R6: wrap from 0xFFFF to 0
      wr_reg(4'd0, 16'h0001);
      tick(65536 - 8);
      rd_reg(4'd8, v);
      rd_reg(4'd8, v2);
      check("R6 wraps", v2, v + 16'd1);
      check("R6 wrapped low", {15'h0, v2 < 16'd100}, 16'h1);

      // R10: a reserved address reads zero and a write there has no effect
      wr_reg(4'd6, 16'hFFFF);
      rd_reg(4'd6, v);
      check("R10 reserved read", v, 16'h0);
      rd_reg(4'd3, v);
      check("R10 config untouched", v, 16'h0);

      // R11: read data holds until the next read strobe
      wr_reg(4'd4, 16'h0009);
      rd_reg(4'd4, v);
      addr = 4'd3;
      tick(2);
      check("R11 registered hold", rdata, 16'h0009);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule